// File: doc/BRIEF.md
# Dual-Bus Post-Modify Address Generator

This block produces word addresses for two independent data memories, called X and Y. Each bus owns two 32-bit pointer registers and one index register. When a transfer request is accepted on a bus, the block presents the selected pointer's current value as a 16-bit word address. It then rewrites that pointer with one of three post-update rules: leave it as it is, step it by one word (+2), or add the bus's index register. Each bus has its own adder, so both buses can update in the same cycle.

Only the low half of a pointer takes part in addressing and in updating. The sum wraps within 16 bits, and the upper half of the pointer keeps its value. Address bit 0 is always zero, both in the presented address and in a rewritten pointer. A single load port writes any pointer or index register, which is how software sets up a walk. Loading a negative index such as -2 or -4 and selecting index mode makes the pointer walk downwards.

Requests and results use valid/ready. A request is taken when `*_req_valid` and `*_req_ready` are both high. The result (address plus the pointer's new full value) then appears registered on the next cycle. While `*_addr_valid` is high and `*_addr_ready` is low, the result is held unchanged and no further request is taken. The load port has no handshake.

Top module: `dsp_xy_agu`

## Requirements
- R1: After synchronous active-high reset, all four pointers and both index registers are zero, both `*_addr_valid` are low and both `*_req_ready` are high.
- R2: `*_req_ready` is high exactly when that bus's result slot is empty or is being consumed. While `*_addr_valid` is high and `*_addr_ready` is low, the address and write-back value stay stable. A request offered while `*_req_ready` is low changes no pointer.
- R3: The address appears with `*_addr_valid` on the cycle after acceptance. It equals bits 15:1 of the selected pointer as it was before the update, with bit 0 zero.
- R4: Mode 2'b00 (hold) leaves bits 31:1 of the pointer unchanged. Mode 2'b11 behaves the same way.
- R5: Mode 2'b01 (step) adds 2 to the low 16 bits of the pointer.
- R6: Mode 2'b10 (index) adds the low 16 bits of that bus's index register to the low 16 bits of the pointer. A negative index (-2, -4) decrements the pointer.
- R7: The low-half sum wraps modulo 2^16 and never carries into bits 31:16, which keep their value. `*_wb_data` shows the pointer's full 32-bit value after the update.
- R8: `x_ptr_sel` picks X pointer A (0) or B (1), and `y_ptr_sel` picks Y pointer A (0) or B (1). `ld_sel` codes are: 0 X A, 1 X B, 2 Y A, 3 Y B, 4 X index, 5 Y index. Codes 6 and 7 write nothing.
- R9: Both buses can accept and update in the same cycle without affecting each other.
- R10: When a load and an accepted update target the same pointer in one cycle, the loaded value is stored and reported on `*_wb_data`. The address still comes from the old value.
- R11: An odd value loaded into a pointer produces an even address, and after any accepted transfer the stored pointer's bit 0 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Load target code |
| ld_data | input | 32 | Load value |
| x_req_valid | input | 1 | X transfer request |
| x_req_ready | output | 1 | X request can be taken |
| x_ptr_sel | input | 1 | X pointer choice |
| x_mode | input | 2 | X post-update mode |
| x_addr_valid | output | 1 | X result valid |
| x_addr_ready | input | 1 | X result consumer ready |
| x_addr | output | 16 | X word address |
| x_wb_data | output | 32 | X pointer after update |
| y_req_valid | input | 1 | Y transfer request |
| y_req_ready | output | 1 | Y request can be taken |
| y_ptr_sel | input | 1 | Y pointer choice |
| y_mode | input | 2 | Y post-update mode |
| y_addr_valid | output | 1 | Y result valid |
| y_addr_ready | input | 1 | Y result consumer ready |
| y_addr | output | 16 | Y word address |
| y_wb_data | output | 32 | Y pointer after update |

## Verification
The pointer walk is driven with repeated steps and with a -2 and a -4 index. This separates the increment path from the index path and shows that negative indices walk downwards. A pointer placed at 0xFFFE with a non-zero upper half tells a 16-bit wrap apart from a 32-bit carry. An odd loaded value tells forced bit 0 apart from pass-through. Concurrent X/Y requests, a load colliding with an update, an unused load code and a stalled result show bus independence, load priority and back-pressure hold.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_STEP  = 2'b01,
    MODE_INDEX = 2'b10,
    MODE_RSVD  = 2'b11
  } upd_mode_e;

  localparam int unsigned PTR_W  = 32;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned NPTR   = 2;
endpackage

// File: rtl/agu_post_adder.sv
module agu_post_adder
  import agu_pkg::*;
#(
  parameter int unsigned PW   = 32,
  parameter int unsigned AW   = 16,
  parameter int unsigned STEP = 2
) (
  input  logic [PW-1:0] cur_ptr,
  input  logic [PW-1:0] idx,
  input  logic [1:0]    mode,
  output logic [AW-1:0] word_addr,
  output logic [PW-1:0] next_ptr
);
  localparam int unsigned UW = PW - AW;

  upd_mode_e     m;
  logic [AW-1:0] delta;
  logic [AW-1:0] low_sum;

  always_comb begin
    m = upd_mode_e'(mode);
    unique case (m)
      MODE_STEP:  delta = AW'(STEP);
      MODE_INDEX: delta = idx[AW-1:0];
      default:    delta = '0;
    endcase
  end

  assign low_sum   = cur_ptr[AW-1:0] + delta;
  assign word_addr = {cur_ptr[AW-1:1], 1'b0};
  assign next_ptr  = {cur_ptr[PW-1:PW-UW], low_sum[AW-1:1], 1'b0};
endmodule

// File: rtl/agu_out_reg.sv
module agu_out_reg #(
  parameter int unsigned DW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r3_valid_after_take: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int unsigned PW   = 32,
  parameter int unsigned AW   = 16,
  parameter int unsigned NP   = 2,
  parameter int unsigned STEP = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         ld_ptr_we,
  input  logic                  ld_idx_we,
  input  logic [PW-1:0]         ld_data,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [$clog2(NP)-1:0] ptr_sel,
  input  logic [1:0]            mode,
  output logic                  addr_valid,
  input  logic                  addr_ready,
  output logic [AW-1:0]         addr,
  output logic [PW-1:0]         wb_data
);
  localparam int unsigned SW = $clog2(NP);
  localparam int unsigned UW = PW - AW;
  localparam int unsigned DW = AW + PW;

  logic [PW-1:0] ptr_q [NP];
  logic [PW-1:0] idx_q;
  logic [PW-1:0] cur_ptr;
  logic [PW-1:0] next_ptr;
  logic [PW-1:0] wb_next;
  logic [AW-1:0] word_addr;
  logic          accept;
  logic [DW-1:0] out_payload;

  assign cur_ptr = ptr_q[ptr_sel];
  assign accept  = req_valid && req_ready;

  agu_post_adder #(.PW(PW), .AW(AW), .STEP(STEP)) u_adder (
    .cur_ptr   (cur_ptr),
    .idx       (idx_q),
    .mode      (mode),
    .word_addr (word_addr),
    .next_ptr  (next_ptr)
  );

  assign wb_next = ld_ptr_we[ptr_sel] ? ld_data : next_ptr;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (ld_idx_we) idx_q <= ld_data;
  end

  for (genvar p = 0; p < NP; p++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) ptr_q[p] <= '0;
      else if (ld_ptr_we[p]) ptr_q[p] <= ld_data;
      else if (accept && ptr_sel == SW'(p)) ptr_q[p] <= next_ptr;
    end

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!(accept && ptr_sel == SW'(p)) && !ld_ptr_we[p]) |=> $stable(ptr_q[p]));
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (rst)
      (accept && ptr_sel == SW'(p) && !ld_ptr_we[p])
        |=> (ptr_q[p][PW-1:PW-UW] == $past(ptr_q[p][PW-1:PW-UW])));
    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
      ld_ptr_we[p] |=> (ptr_q[p] == $past(ld_data)));
    a_r11_even_after_update: assert property (@(posedge clk) disable iff (rst)
      (accept && ptr_sel == SW'(p) && !ld_ptr_we[p]) |=> (ptr_q[p][0] == 1'b0));
  end

  assign out_payload = {word_addr, wb_next};

  agu_out_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (out_payload),
    .out_valid (addr_valid),
    .out_ready (addr_ready),
    .out_data  ({addr, wb_data})
  );

  a_r3_addr_even: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> (addr[0] == 1'b0));
  a_r2_stall_no_update: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && ld_ptr_we == '0) |=> $stable(cur_ptr) || $changed(ptr_sel));
endmodule

// File: rtl/dsp_xy_agu.sv
module dsp_xy_agu
  import agu_pkg::*;
#(
  parameter int unsigned PW   = PTR_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NP   = NPTR,
  parameter int unsigned STEP = 2,
  parameter int unsigned LSW  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic [LSW-1:0]        ld_sel,
  input  logic [PW-1:0]         ld_data,
  input  logic                  x_req_valid,
  output logic                  x_req_ready,
  input  logic [$clog2(NP)-1:0] x_ptr_sel,
  input  logic [1:0]            x_mode,
  output logic                  x_addr_valid,
  input  logic                  x_addr_ready,
  output logic [AW-1:0]         x_addr,
  output logic [PW-1:0]         x_wb_data,
  input  logic                  y_req_valid,
  output logic                  y_req_ready,
  input  logic [$clog2(NP)-1:0] y_ptr_sel,
  input  logic [1:0]            y_mode,
  output logic                  y_addr_valid,
  input  logic                  y_addr_ready,
  output logic [AW-1:0]         y_addr,
  output logic [PW-1:0]         y_wb_data
);
  localparam int unsigned X_IDX_CODE = 2 * NP;
  localparam int unsigned Y_IDX_CODE = 2 * NP + 1;

  logic [NP-1:0] x_ld_ptr;
  logic [NP-1:0] y_ld_ptr;
  logic          x_ld_idx;
  logic          y_ld_idx;

  for (genvar p = 0; p < NP; p++) begin : g_dec
    assign x_ld_ptr[p] = ld_en && (ld_sel == LSW'(p));
    assign y_ld_ptr[p] = ld_en && (ld_sel == LSW'(NP + p));
  end
  assign x_ld_idx = ld_en && (ld_sel == LSW'(X_IDX_CODE));
  assign y_ld_idx = ld_en && (ld_sel == LSW'(Y_IDX_CODE));

  agu_lane #(.PW(PW), .AW(AW), .NP(NP), .STEP(STEP)) u_x (
    .clk        (clk),
    .rst        (rst),
    .ld_ptr_we  (x_ld_ptr),
    .ld_idx_we  (x_ld_idx),
    .ld_data    (ld_data),
    .req_valid  (x_req_valid),
    .req_ready  (x_req_ready),
    .ptr_sel    (x_ptr_sel),
    .mode       (x_mode),
    .addr_valid (x_addr_valid),
    .addr_ready (x_addr_ready),
    .addr       (x_addr),
    .wb_data    (x_wb_data)
  );

  agu_lane #(.PW(PW), .AW(AW), .NP(NP), .STEP(STEP)) u_y (
    .clk        (clk),
    .rst        (rst),
    .ld_ptr_we  (y_ld_ptr),
    .ld_idx_we  (y_ld_idx),
    .ld_data    (ld_data),
    .req_valid  (y_req_valid),
    .req_ready  (y_req_ready),
    .ptr_sel    (y_ptr_sel),
    .mode       (y_mode),
    .addr_valid (y_addr_valid),
    .addr_ready (y_addr_ready),
    .addr       (y_addr),
    .wb_data    (y_wb_data)
  );

  a_r8_one_load_target: assert property (@(posedge clk) disable iff (rst)
    $countones({x_ld_ptr, y_ld_ptr, x_ld_idx, y_ld_idx}) <= 1);
  a_r9_x_ready_own: assert property (@(posedge clk) disable iff (rst)
    !x_addr_valid |-> x_req_ready);
  a_r9_y_ready_own: assert property (@(posedge clk) disable iff (rst)
    !y_addr_valid |-> y_req_ready);
endmodule

// File: tb/dsp_xy_agu_tb.sv
module dsp_xy_agu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [2:0]  ld_sel;
  logic [31:0] ld_data;
  logic        x_req_valid, x_req_ready, x_ptr_sel, x_addr_valid, x_addr_ready;
  logic [1:0]  x_mode;
  logic [15:0] x_addr;
  logic [31:0] x_wb_data;
  logic        y_req_valid, y_req_ready, y_ptr_sel, y_addr_valid, y_addr_ready;
  logic [1:0]  y_mode;
  logic [15:0] y_addr;
  logic [31:0] y_wb_data;

  always #10 clk = ~clk;

  dsp_xy_agu u_dut (.*);

  typedef struct {
    logic [15:0] addr;
    logic [31:0] wb;
    string       tag;
  } exp_t;

  exp_t xq[$];
  exp_t yq[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] xp [2];
  logic [31:0] yp [2];
  logic [31:0] xi, yi;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_upd(input logic [31:0] p, input logic [1:0] m,
                                        input logic [31:0] ix);
    logic [15:0] lo;
    lo = p[15:0];
    if (m == 2'b01) lo = lo + 16'd2;
    else if (m == 2'b10) lo = lo + ix[15:0];
    return {p[31:16], lo[15:1], 1'b0};
  endfunction

  // Driver: one cycle of stimulus, expected results pushed to the scoreboard.
  task automatic step(input logic xe, input logic xs, input logic [1:0] xm,
                      input logic ye, input logic ys, input logic [1:0] ym,
                      input logic ld, input logic [2:0] ls, input logic [31:0] ldat,
                      input string tag);
    exp_t e;
    logic [31:0] n;
    @(negedge clk);
    x_req_valid = xe; x_ptr_sel = xs; x_mode = xm;
    y_req_valid = ye; y_ptr_sel = ys; y_mode = ym;
    ld_en = ld; ld_sel = ls; ld_data = ldat;
    if (xe) begin
      n = m_upd(xp[xs], xm, xi);
      if (ld && ls == {2'b00, xs}) n = ldat;
      e.addr = {xp[xs][15:1], 1'b0}; e.wb = n; e.tag = tag;
      xp[xs] = n; xq.push_back(e);
    end
    if (ye) begin
      n = m_upd(yp[ys], ym, yi);
      if (ld && ls == {2'b01, ys}) n = ldat;
      e.addr = {yp[ys][15:1], 1'b0}; e.wb = n; e.tag = tag;
      yp[ys] = n; yq.push_back(e);
    end
    if (ld) begin
      case (ls)
        3'd0: xp[0] = ldat;
        3'd1: xp[1] = ldat;
        3'd2: yp[0] = ldat;
        3'd3: yp[1] = ldat;
        3'd4: xi = ldat;
        3'd5: yi = ldat;
        default: ;
      endcase
    end
    @(negedge clk);
    x_req_valid = 1'b0; y_req_valid = 1'b0; ld_en = 1'b0;
  endtask

  task automatic load(input logic [2:0] ls, input logic [31:0] d, input string tag);
    step(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, ls, d, tag);
  endtask

  // Monitor: pops and compares as results are consumed.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (x_addr_valid && x_addr_ready) begin
        if (xq.size() == 0) chk("R3 unexpected X result", 32'd1, 32'd0);
        else begin
          e = xq.pop_front();
          chk({e.tag, " X addr"}, {16'h0, x_addr}, {16'h0, e.addr});
          chk({e.tag, " X wb"}, x_wb_data, e.wb);
        end
      end
      if (y_addr_valid && y_addr_ready) begin
        if (yq.size() == 0) chk("R3 unexpected Y result", 32'd1, 32'd0);
        else begin
          e = yq.pop_front();
          chk({e.tag, " Y addr"}, {16'h0, y_addr}, {16'h0, e.addr});
          chk({e.tag, " Y wb"}, y_wb_data, e.wb);
        end
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 20000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst = 1'b1; ld_en = 1'b0; ld_sel = '0; ld_data = '0;
    x_req_valid = 1'b0; x_ptr_sel = 1'b0; x_mode = 2'b00; x_addr_ready = 1'b1;
    y_req_valid = 1'b0; y_ptr_sel = 1'b0; y_mode = 2'b00; y_addr_ready = 1'b1;
    xp[0] = '0; xp[1] = '0; yp[0] = '0; yp[1] = '0; xi = '0; yi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 x_addr_valid", {31'h0, x_addr_valid}, 32'd0);
    chk("R1 y_addr_valid", {31'h0, y_addr_valid}, 32'd0);
    chk("R1 x_req_ready", {31'h0, x_req_ready}, 32'd1);
    chk("R1 y_req_ready", {31'h0, y_req_ready}, 32'd1);
    step(1, 0, 2'b00, 1, 1, 2'b00, 0, 0, 0, "R1 reset ptr");
    step(1, 1, 2'b00, 1, 0, 2'b00, 0, 0, 0, "R1 reset ptr");

    load(3'd0, 32'h1234_0010, "load");
    load(3'd1, 32'h0000_0101, "load");
    load(3'd4, 32'hFFFF_FFFE, "load");
    load(3'd2, 32'hABCD_FFFE, "load");
    load(3'd3, 32'h5555_0000, "load");
    load(3'd5, 32'h0000_0040, "load");

    step(1, 0, 2'b01, 0, 0, 0, 0, 0, 0, "R5 step");
    step(1, 0, 2'b01, 0, 0, 0, 0, 0, 0, "R5 step again");
    step(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, "R6 index -2");
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R11 odd load");
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R11 bit0 stored zero");
    step(1, 0, 2'b11, 0, 0, 0, 0, 0, 0, "R4 mode 11 hold");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R4 mode 00 hold");
    step(0, 0, 0, 1, 0, 2'b01, 0, 0, 0, "R7 wrap");
    step(0, 0, 0, 1, 0, 2'b00, 0, 0, 0, "R7 upper kept");
    step(1, 1, 2'b01, 1, 1, 2'b10, 0, 0, 0, "R9 both buses");
    step(1, 1, 2'b00, 1, 1, 2'b00, 0, 0, 0, "R8 pointer B kept");
    step(1, 0, 2'b01, 0, 0, 0, 1, 3'd0, 32'h7777_0200, "R10 load wins");
    step(1, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R10 loaded value used");
    load(3'd6, 32'hDEAD_BEEE, "R8 code 6");
    load(3'd7, 32'hDEAD_BEEE, "R8 code 7");
    step(1, 0, 2'b10, 1, 0, 2'b10, 0, 0, 0, "R8 unused codes ignored");
    step(1, 1, 2'b00, 1, 1, 2'b00, 0, 0, 0, "R8 unused codes ignored");
    load(3'd5, 32'hFFFF_FFFC, "load");
    step(0, 0, 0, 1, 1, 2'b10, 0, 0, 0, "R6 index -4");
    step(0, 0, 0, 1, 1, 2'b10, 0, 0, 0, "R6 index -4 again");

    // Back-pressure on X (R2)
    @(negedge clk);
    x_addr_ready = 1'b0;
    step(1, 1, 2'b01, 0, 0, 0, 0, 0, 0, "R2 stalled result");
    chk("R2 valid held", {31'h0, x_addr_valid}, 32'd1);
    chk("R2 ready low when full", {31'h0, x_req_ready}, 32'd0);
    held = x_addr;
    x_req_valid = 1'b1; x_ptr_sel = 1'b1; x_mode = 2'b01;
    repeat (3) begin
      @(negedge clk);
      chk("R2 addr stable", {16'h0, x_addr}, {16'h0, held});
      chk("R2 ready stays low", {31'h0, x_req_ready}, 32'd0);
    end
    x_req_valid = 1'b0;
    @(negedge clk);
    x_addr_ready = 1'b1;
    @(negedge clk);
    step(1, 1, 2'b00, 0, 0, 0, 0, 0, 0, "R2 refused request no update");

    repeat (4) @(negedge clk);
    chk("R3 X queue drained", xq.size(), 0);
    chk("R3 Y queue drained", yq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule